// File: doc/BRIEF.md
# Accumulator Shift-Left Unit

This unit doubles a signed operand by moving it one place toward the most significant end and feeding a zero in at the bottom. It works on a 36-bit extended accumulator, built from a 4-bit guard extension over two 16-bit words, or on a plain 16-bit register. It also produces the arithmetic flags a signal-processing datapath expects after such a step. These flags are carry, overflow, zero, negative, unnormalized, extension-in-use and a sticky overflow record. The condition code byte stays visible on plain status pins between operations.

Operands enter on a valid/ready stream and results leave on another through a single output register. An operand is taken on a clock edge where `in_valid` and `in_ready` are both high. `in_ready` is high whenever the output register is empty or is being drained in the same cycle. While `out_valid` is high and `out_ready` is low, the result is held steady and no new operand is taken. The flag byte changes on the edge that accepts an operand. The sticky overflow flag can be cleared with a separate control pin.

Top module: `acc_shl_unit`

## Requirements
- R1: In accumulator mode (`in_wide`=1), `out_data` is `in_data` moved left one place with bit 0 zero and bit 35 dropped, valid on the cycle after acceptance.
- R2: In register mode (`in_wide`=0), `out_data[15:0]` is `in_data[15:0]` moved left one place with bit 0 zero, and `out_data[35:16]` is zero. Input bits 35..16 are ignored.
- R3: Carry (`ccr[0]`) takes the operand's top bit before the shift: bit 35 in accumulator mode, bit 15 in register mode.
- R4: Negative (`ccr[3]`) is the result's top bit (bit 35 or bit 15). Zero (`ccr[2]`) is set when the whole result is zero.
- R5: Overflow (`ccr[1]`) is set in accumulator mode when result bit 35 differs from operand bit 35. In register mode `ccr[1]`, `ccr[4]` and `ccr[5]` are cleared.
- R6: Extension-in-use (`ccr[5]`) is set in accumulator mode unless result bits 35 down to 31 are all equal.
- R7: Unnormalized (`ccr[4]`) is set in accumulator mode when result bit 31 equals result bit 30.
- R8: Sticky overflow (`ccr[6]`) is set by any accepted operation that sets `ccr[1]`. It stays set until reset or a cycle with `l_clr` high. An overflowing operation in the same cycle as `l_clr` leaves it set.
- R9: Bit `ccr[7]` is not touched by shifting and stays at its reset value of zero.
- R10: `in_ready` equals `!out_valid || out_ready`. While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_data` is unchanged.
- R11: After reset `out_valid` is low, `out_data` is zero, `ccr` is zero and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operand offered |
| in_ready | output | 1 | Operand can be taken this cycle |
| in_wide | input | 1 | 1 = 36-bit accumulator, 0 = 16-bit register |
| in_data | input | 36 | Operand value |
| out_valid | output | 1 | Result held in output register |
| out_ready | input | 1 | Consumer takes the result |
| out_data | output | 36 | Shifted result |
| l_clr | input | 1 | Clears the sticky overflow flag |
| ccr | output | 8 | Flags: C=0, V=1, Z=2, N=3, U=4, E=5, L=6, bit 7 held |

## Verification
A vector table drives a mixed accumulator value, all zeros, all ones, a single bit at position 29, 30 or 35, and a pair at 31:30. Together these separate carry from overflow, extension-in-use from its absence, and normalized from unnormalized results, on both sides of the word boundary. Register-mode vectors carry junk in the upper bits, which shows that only the low word takes part, and they include a case where the result becomes zero. Directed sequences set, hold and clear the sticky flag, including a clear that arrives in the same cycle as an overflow. A stall shows that back-pressure freezes the result and blocks new operands.

// File: rtl/acc_shl_pkg.sv
package acc_shl_pkg;
  localparam int CCR_W  = 8;
  localparam int C_BIT  = 0;
  localparam int V_BIT  = 1;
  localparam int Z_BIT  = 2;
  localparam int N_BIT  = 3;
  localparam int U_BIT  = 4;
  localparam int E_BIT  = 5;
  localparam int L_BIT  = 6;
  localparam int SZ_BIT = 7;

  typedef struct packed {
    logic carry;
    logic ovf;
    logic zero;
    logic neg;
    logic unnorm;
    logic ext_use;
  } shl_flags_t;
endpackage

// File: rtl/acc_shl_core.sv
module acc_shl_core
  import acc_shl_pkg::*;
#(
  parameter int EXT_W  = 4,
  parameter int WORD_W = 16,
  localparam int ACC_W = EXT_W + 2 * WORD_W
) (
  input  logic             wide,
  input  logic [ACC_W-1:0] op,
  output logic [ACC_W-1:0] res,
  output shl_flags_t       fl
);
  localparam int HI_MSB = 2 * WORD_W - 1;
  localparam int TOP_N  = ACC_W - HI_MSB;

  logic [ACC_W-1:0] acc_res;
  logic [ACC_W-1:0] reg_res;
  logic [TOP_N-1:0] top_bits;

  assign acc_res  = {op[ACC_W-2:0], 1'b0};
  assign reg_res  = {{(ACC_W-WORD_W){1'b0}}, op[WORD_W-2:0], 1'b0};
  assign top_bits = acc_res[ACC_W-1:HI_MSB];

  always_comb begin
    if (wide) begin
      res        = acc_res;
      fl.carry   = op[ACC_W-1];
      fl.ovf     = op[ACC_W-1] ^ acc_res[ACC_W-1];
      fl.zero    = (acc_res == '0);
      fl.neg     = acc_res[ACC_W-1];
      fl.ext_use = !((&top_bits) || !(|top_bits));
      fl.unnorm  = (acc_res[HI_MSB] == acc_res[HI_MSB-1]);
    end else begin
      res        = reg_res;
      fl.carry   = op[WORD_W-1];
      fl.ovf     = 1'b0;
      fl.zero    = (reg_res[WORD_W-1:0] == '0);
      fl.neg     = reg_res[WORD_W-1];
      fl.ext_use = 1'b0;
      fl.unnorm  = 1'b0;
    end
  end
endmodule

// File: rtl/acc_shl_ccr.sv
module acc_shl_ccr
  import acc_shl_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             upd,
  input  shl_flags_t       fl,
  input  logic             l_clr,
  output logic [CCR_W-1:0] ccr
);
  logic [CCR_W-1:0] ccr_q;
  logic             sticky_nxt;

  assign sticky_nxt = (upd && fl.ovf) || (ccr_q[L_BIT] && !l_clr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ccr_q <= '0;
    end else begin
      ccr_q[L_BIT] <= sticky_nxt;
      if (upd) begin
        ccr_q[C_BIT] <= fl.carry;
        ccr_q[V_BIT] <= fl.ovf;
        ccr_q[Z_BIT] <= fl.zero;
        ccr_q[N_BIT] <= fl.neg;
        ccr_q[U_BIT] <= fl.unnorm;
        ccr_q[E_BIT] <= fl.ext_use;
      end
    end
  end

  assign ccr = ccr_q;
endmodule

// File: rtl/acc_shl_obuf.sv
module acc_shl_obuf #(
  parameter int W = 36
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_valid,
  output logic         load_ready,
  input  logic [W-1:0] load_data,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data
);
  logic         full_q;
  logic [W-1:0] data_q;

  assign load_ready = !full_q || out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full_q <= 1'b0;
      data_q <= '0;
    end else if (load_ready) begin
      full_q <= load_valid;
      if (load_valid) data_q <= load_data;
    end
  end

  assign out_valid = full_q;
  assign out_data  = data_q;
endmodule

// File: rtl/acc_shl_unit.sv
module acc_shl_unit
  import acc_shl_pkg::*;
#(
  parameter int EXT_W  = 4,
  parameter int WORD_W = 16,
  localparam int ACC_W = EXT_W + 2 * WORD_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic             in_wide,
  input  logic [ACC_W-1:0] in_data,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [ACC_W-1:0] out_data,
  input  logic             l_clr,
  output logic [CCR_W-1:0] ccr
);
  logic [ACC_W-1:0] shl_res;
  shl_flags_t       shl_fl;
  logic             take;

  assign take = in_valid && in_ready;

  acc_shl_core #(.EXT_W(EXT_W), .WORD_W(WORD_W)) u_core (
    .wide (in_wide),
    .op   (in_data),
    .res  (shl_res),
    .fl   (shl_fl)
  );

  acc_shl_obuf #(.W(ACC_W)) u_obuf (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_valid (in_valid),
    .load_ready (in_ready),
    .load_data  (shl_res),
    .out_valid  (out_valid),
    .out_ready  (out_ready),
    .out_data   (out_data)
  );

  acc_shl_ccr u_ccr (
    .clk   (clk),
    .rst_n (rst_n),
    .upd   (take),
    .fl    (shl_fl),
    .l_clr (l_clr),
    .ccr   (ccr)
  );
endmodule

// File: rtl/acc_shl_chk.sv
module acc_shl_chk
  import acc_shl_pkg::*;
#(
  parameter int EXT_W  = 4,
  parameter int WORD_W = 16,
  localparam int ACC_W = EXT_W + 2 * WORD_W
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_ready,
  input logic             in_wide,
  input logic [ACC_W-1:0] in_data,
  input logic             out_valid,
  input logic             out_ready,
  input logic [ACC_W-1:0] out_data,
  input logic             l_clr,
  input logic [CCR_W-1:0] ccr
);
  logic acc_t;
  assign acc_t = in_valid && in_ready;

  a_r1_acc_result: assert property (@(posedge clk) disable iff (!rst_n)
    acc_t && in_wide |=> out_data == {$past(in_data[ACC_W-2:0]), 1'b0});

  a_r2_reg_result: assert property (@(posedge clk) disable iff (!rst_n)
    acc_t && !in_wide |=> out_data == {{(ACC_W-WORD_W){1'b0}}, $past(in_data[WORD_W-2:0]), 1'b0});

  a_r3_carry_acc: assert property (@(posedge clk) disable iff (!rst_n)
    acc_t && in_wide |=> ccr[C_BIT] == $past(in_data[ACC_W-1]));

  a_r4_zero_flag: assert property (@(posedge clk) disable iff (!rst_n)
    acc_t |=> ccr[Z_BIT] == (out_data == '0));

  a_r5_ovf_acc: assert property (@(posedge clk) disable iff (!rst_n)
    acc_t && in_wide |=> ccr[V_BIT] == (out_data[ACC_W-1] != $past(in_data[ACC_W-1])));

  a_r8_sticky_hold: assert property (@(posedge clk) disable iff (!rst_n)
    ccr[L_BIT] && !l_clr |=> ccr[L_BIT]);

  a_r8_sticky_set: assert property (@(posedge clk) disable iff (!rst_n)
    acc_t && in_wide && (in_data[ACC_W-1] != in_data[ACC_W-2]) |=> ccr[L_BIT]);

  a_r10_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data));

  a_r10_ready_rule: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready == (!out_valid || out_ready));
endmodule

bind acc_shl_unit acc_shl_chk #(.EXT_W(EXT_W), .WORD_W(WORD_W)) u_chk (.*);

// File: tb/sim_acc_shl_unit.sv
`timescale 1ns/1ps
module sim_acc_shl_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic        in_wide = 1'b0;
  logic [35:0] in_data = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [35:0] out_data;
  logic        l_clr = 1'b0;
  logic [7:0]  ccr;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  acc_shl_unit u0 (.*);

  typedef struct packed {
    logic        wide;
    logic [35:0] din;
    logic [35:0] dout;
    logic [5:0]  fl;   // E U N Z V C
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VEC [NV] = '{
    '{1'b1, 36'hA01230123, 36'h402460246, 6'h33},
    '{1'b1, 36'h000000000, 36'h000000000, 6'h14},
    '{1'b1, 36'hFFFFFFFFF, 36'hFFFFFFFFE, 6'h19},
    '{1'b1, 36'h040000000, 36'h080000000, 6'h20},
    '{1'b1, 36'h800000000, 36'h000000000, 6'h17},
    '{1'b1, 36'h020000000, 36'h040000000, 6'h00},
    '{1'b0, 36'h000008001, 36'h000000002, 6'h01},
    '{1'b0, 36'hFFFFF4000, 36'h000008000, 6'h08},
    '{1'b0, 36'h000008000, 36'h000000000, 6'h05},
    '{1'b1, 36'h0C0000000, 36'h180000000, 6'h20}
  };

  task automatic chk(input string req, input logic [35:0] act, input logic [35:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic send(input logic wide, input logic [35:0] d);
    @(negedge clk);
    in_valid = 1'b1;
    in_wide  = wide;
    in_data  = d;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R11 reset state
    chk("R11 out_valid", 36'(out_valid), 36'd0);
    chk("R11 out_data", out_data, 36'd0);
    chk("R11 ccr", 36'(ccr), 36'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R11 in_ready", 36'(in_ready), 36'd1);

    // vector table: R1 R2 R3 R4 R5 R6 R7 R9
    for (int i = 0; i < NV; i++) begin
      send(VEC[i].wide, VEC[i].din);
      chk(VEC[i].wide ? "R1 result" : "R2 result", out_data, VEC[i].dout);
      chk("R3 R4 R5 R6 R7 flags", 36'(ccr[5:0]), 36'(VEC[i].fl));
      chk("R9 bit7", 36'(ccr[7]), 36'd0);
      chk("R10 out_valid", 36'(out_valid), 36'd1);
    end

    // R8 sticky overflow: clear, no-overflow op keeps it clear
    @(negedge clk); l_clr = 1'b1;
    @(negedge clk); l_clr = 1'b0;
    chk("R8 cleared", 36'(ccr[6]), 36'd0);
    send(1'b1, 36'h000000001);
    chk("R8 no set", 36'(ccr[6]), 36'd0);
    send(1'b1, 36'h400000000);
    chk("R8 set by overflow", 36'(ccr[6]), 36'd1);
    send(1'b1, 36'h000000002);
    chk("R8 held", 36'(ccr[6]), 36'd1);
    chk("R8 V clear", 36'(ccr[1]), 36'd0);
    // clear together with overflowing op: set wins
    @(negedge clk);
    l_clr = 1'b1; in_valid = 1'b1; in_wide = 1'b1; in_data = 36'h800000001;
    @(posedge clk);
    @(negedge clk);
    l_clr = 1'b0; in_valid = 1'b0;
    chk("R8 set beats clear", 36'(ccr[6]), 36'd1);
    // register-mode op does not set L
    @(negedge clk); l_clr = 1'b1;
    @(negedge clk); l_clr = 1'b0;
    send(1'b0, 36'h00000C000);
    chk("R8 reg mode no set", 36'(ccr[6]), 36'd0);
    chk("R5 reg mode V", 36'(ccr[1]), 36'd0);

    // R10 back-pressure
    @(negedge clk);
    out_ready = 1'b0;
    in_valid = 1'b1; in_wide = 1'b1; in_data = 36'h000000003;
    @(posedge clk);
    @(negedge clk);
    in_data = 36'h000000010;
    chk("R10 in_ready low", 36'(in_ready), 36'd0);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk("R10 held data", out_data, 36'h000000006);
      chk("R10 held valid", 36'(out_valid), 36'd1);
    end
    out_ready = 1'b1;
    @(negedge clk);
    chk("R10 in_ready", 36'(in_ready), 36'd1);
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    chk("R10 next item", out_data, 36'h000000020);
    @(negedge clk);
    chk("R10 drained", 36'(out_valid), 36'd0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule